// File: doc/BRIEF.md
# Hart Step Sequencer

This block drives the outer loop of a simple processor model, one loop iteration at a time. It first checks for a pending interrupt. If none is pending, it asks for an instruction fetch, then for a decode, then for an execute, and waits for each answer before it moves on. At the end of each iteration it loads the program counter, reports whether an instruction retired, raises a trap report when the iteration ended in an interrupt or an exception, and advances a step count according to its own rule for each outcome.

The block also counts the iterations that finish while the run is still active. When that count reaches a runtime limit it emits a platform tick and starts counting again from zero. A done flag ends the run at the end of an iteration. The block then halts and gives a pass or fail verdict from an exit code. Interrupt selection, decoding and execution are done by neighbouring logic that answers the request strobes. The trap handler's entry address comes in on an input.

Top module: `hart_step_seq`

## Requirements
- R1: After reset, `pc_o` equals the RESET_PC parameter, `step_count_o` is zero, and `commit_o`, `retire_o`, `trap_valid_o`, `tick_o`, `done_o`, `pass_o` and `fail_o` are all low.
- R2: When `irq_pending` is high at the start of an iteration, the iteration ends in the next cycle without any `fetch_req`. It reports trap kind 1 with `trap_val_o` equal to the zero-extended `irq_cause`, loads `pc_o` from `trap_vec`, does not retire, and leaves the step count unchanged.
- R3: A fetch answered with `fetch_fault` high ends the iteration. It reports trap kind 2 with `trap_val_o` equal to `fetch_fault_addr`, loads `pc_o` from `trap_vec`, does not retire, and leaves the step count unchanged.
- R4: A decode answered with `dec_ok` low ends the iteration with trap kind 3. `trap_val_o` carries the instruction bits zero-extended: only bits 15:0 if the instruction is compressed, otherwise all 32 bits. `pc_o` is loaded from `trap_vec`, nothing retires, and the step count rises by one.
- R5: An instruction is compressed when its bits 1:0 are not 2'b11. After a successful execute, `pc_o` rises by 2 for a compressed instruction and by 4 otherwise, and the step count rises by one.
- R6: `retire_o` is a one-cycle pulse in the completion cycle. It is high only when an execute finishes with `exec_retire` high, and never together with `trap_valid_o`.
- R7: Each iteration ends with one single-cycle `commit_o` pulse. The iteration's `pc_o`, `retire_o`, trap report and tick are valid in that cycle. When every answer is immediate, the pulse comes 1, 2, 3 or 4 cycles after the iteration starts, for an interrupt, fetch fault, decode failure or execute respectively.
- R8: An iteration that ends with `done_in` low advances an iteration counter. When the advanced count reaches `insns_per_tick`, `tick_o` pulses with `commit_o` and the counter returns to zero.
- R9: An iteration that ends with `done_in` high produces no tick. It sets `done_o`, and sets `pass_o` if `exit_code` is zero and `fail_o` otherwise. After that the block issues no request and no commit, and `pc_o` holds.
- R10: At most one of `fetch_req`, `dec_req` and `exec_req` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| irq_pending | input | 1 | An interrupt is waiting to be serviced |
| irq_cause | input | CAUSE_W | Cause code of the pending interrupt |
| trap_vec | input | XLEN | Entry address used when an interrupt or exception ends an iteration |
| fetch_req | output | 1 | Fetch of the instruction at `pc_o` requested |
| fetch_valid | input | 1 | Fetch answer is present |
| fetch_fault | input | 1 | The fetch failed |
| fetch_fault_addr | input | XLEN | Address reported for a failed fetch |
| fetch_insn | input | 32 | Fetched instruction bits (compressed instructions in bits 15:0) |
| dec_req | output | 1 | Decode of `insn_o` requested |
| insn_o | output | 32 | Instruction held for decode and execute |
| dec_valid | input | 1 | Decode answer is present |
| dec_ok | input | 1 | The instruction decoded |
| exec_req | output | 1 | Execute requested |
| exec_done | input | 1 | Execute finished |
| exec_retire | input | 1 | The executed instruction retires |
| insns_per_tick | input | TICK_W | Iterations per platform tick, at least 1 |
| done_in | input | 1 | Run is finished, sampled when an iteration ends |
| exit_code | input | EXIT_W | Exit status, zero for success |
| pc_o | output | XLEN | Program counter |
| commit_o | output | 1 | Iteration completed in this cycle |
| retire_o | output | 1 | One instruction retired |
| step_count_o | output | CNT_W | Step count |
| trap_valid_o | output | 1 | The iteration ended in a trap |
| trap_kind_o | output | 2 | 1 interrupt, 2 fetch fault, 3 illegal instruction, 0 none |
| trap_val_o | output | XLEN | Cause, faulting address or instruction bits of the last trap |
| tick_o | output | 1 | Platform tick pulse |
| done_o | output | 1 | Run halted |
| pass_o | output | 1 | Halted with a zero exit code |
| fail_o | output | 1 | Halted with a nonzero exit code |

## Verification
The assertions assume that `insns_per_tick` is at least 1 and that answer inputs change only while the matching request is up or between iterations. They also assume `trap_vec` is held stable while an iteration is ending, because the trap-entry property compares `pc_o` with the vector sampled at that edge. The stimulus picks the tick limit from 1 to 7, and changes it, the trap vector, the outcome and the instruction bits only in the cycle that follows a commit pulse. The decode and execute answers are held valid for a whole iteration, which gives every outcome a fixed and checkable latency.

// File: rtl/hss_pkg.sv
package hss_pkg;

  typedef enum logic [1:0] {
    TK_NONE  = 2'd0,
    TK_IRQ   = 2'd1,
    TK_FETCH = 2'd2,
    TK_ILL   = 2'd3
  } trap_kind_e;

  typedef enum logic [2:0] {
    ST_CHECK  = 3'd0,
    ST_FETCH  = 3'd1,
    ST_DECODE = 3'd2,
    ST_EXEC   = 3'd3,
    ST_HALT   = 3'd4
  } seq_state_e;

  localparam int unsigned INSN_W = 32;

endpackage

// File: rtl/hss_ctrl.sv
module hss_ctrl
  import hss_pkg::*;
#(
  parameter int unsigned XLEN    = 32,
  parameter int unsigned CAUSE_W = 6,
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned EXIT_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               irq_pending,
  input  logic [CAUSE_W-1:0] irq_cause,
  input  logic               fetch_valid,
  input  logic               fetch_fault,
  input  logic [XLEN-1:0]    fetch_fault_addr,
  input  logic [INSN_W-1:0]  fetch_insn,
  input  logic               dec_valid,
  input  logic               dec_ok,
  input  logic               exec_done,
  input  logic               exec_retire,
  input  logic               done_in,
  input  logic [EXIT_W-1:0]  exit_code,
  output logic               fetch_req,
  output logic               dec_req,
  output logic               exec_req,
  output logic [INSN_W-1:0]  insn_o,
  output logic               is_comp,
  output logic               fin,
  output logic               fin_vec,
  output logic               commit_o,
  output logic               retire_o,
  output logic               trap_valid_o,
  output trap_kind_e         trap_kind_o,
  output logic [XLEN-1:0]    trap_val_o,
  output logic [CNT_W-1:0]   step_count_o,
  output logic               done_o,
  output logic               pass_o,
  output logic               fail_o
);

  seq_state_e          state_q, state_d;
  logic [INSN_W-1:0]   insn_q, insn_d;
  trap_kind_e          fin_kind;
  logic [XLEN-1:0]     fin_val;
  logic                fin_retire;
  logic                fin_step;
  logic [XLEN-1:0]     ill_val;

  logic                commit_q, retire_q, trap_valid_q;
  trap_kind_e          kind_q;
  logic [XLEN-1:0]     val_q;
  logic [CNT_W-1:0]    step_q;
  logic                done_q, pass_q, fail_q;

  assign is_comp = (insn_q[1:0] != 2'b11);
  assign ill_val = is_comp ? XLEN'(insn_q[15:0]) : XLEN'(insn_q);

  // next-state process
  always_comb begin
    state_d    = state_q;
    insn_d     = insn_q;
    fin        = 1'b0;
    fin_vec    = 1'b0;
    fin_kind   = TK_NONE;
    fin_val    = '0;
    fin_retire = 1'b0;
    fin_step   = 1'b0;
    fetch_req  = 1'b0;
    dec_req    = 1'b0;
    exec_req   = 1'b0;
    case (state_q)
      ST_CHECK: begin
        if (irq_pending) begin
          fin      = 1'b1;
          fin_vec  = 1'b1;
          fin_kind = TK_IRQ;
          fin_val  = XLEN'(irq_cause);
        end else begin
          state_d = ST_FETCH;
        end
      end
      ST_FETCH: begin
        fetch_req = 1'b1;
        if (fetch_valid) begin
          if (fetch_fault) begin
            fin      = 1'b1;
            fin_vec  = 1'b1;
            fin_kind = TK_FETCH;
            fin_val  = fetch_fault_addr;
          end else begin
            insn_d  = fetch_insn;
            state_d = ST_DECODE;
          end
        end
      end
      ST_DECODE: begin
        dec_req = 1'b1;
        if (dec_valid) begin
          if (!dec_ok) begin
            fin      = 1'b1;
            fin_vec  = 1'b1;
            fin_kind = TK_ILL;
            fin_val  = ill_val;
            fin_step = 1'b1;
          end else begin
            state_d = ST_EXEC;
          end
        end
      end
      ST_EXEC: begin
        exec_req = 1'b1;
        if (exec_done) begin
          fin        = 1'b1;
          fin_retire = exec_retire;
          fin_step   = 1'b1;
        end
      end
      default: begin
        state_d = ST_HALT;
      end
    endcase
    if (fin) begin
      state_d = done_in ? ST_HALT : ST_CHECK;
    end
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_CHECK;
      insn_q       <= '0;
      commit_q     <= 1'b0;
      retire_q     <= 1'b0;
      trap_valid_q <= 1'b0;
      kind_q       <= TK_NONE;
      val_q        <= '0;
      step_q       <= '0;
      done_q       <= 1'b0;
      pass_q       <= 1'b0;
      fail_q       <= 1'b0;
    end else begin
      state_q      <= state_d;
      insn_q       <= insn_d;
      commit_q     <= fin;
      retire_q     <= fin & fin_retire;
      trap_valid_q <= fin & (fin_kind != TK_NONE);
      kind_q       <= fin ? fin_kind : TK_NONE;
      if (fin && (fin_kind != TK_NONE)) begin
        val_q <= fin_val;
      end
      if (fin && fin_step) begin
        step_q <= step_q + CNT_W'(1);
      end
      if (fin && done_in) begin
        done_q <= 1'b1;
        pass_q <= (exit_code == '0);
        fail_q <= (exit_code != '0);
      end
    end
  end

  assign insn_o       = insn_q;
  assign commit_o     = commit_q;
  assign retire_o     = retire_q;
  assign trap_valid_o = trap_valid_q;
  assign trap_kind_o  = kind_q;
  assign trap_val_o   = val_q;
  assign step_count_o = step_q;
  assign done_o       = done_q;
  assign pass_o       = pass_q;
  assign fail_o       = fail_q;

  AST_ONE_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fetch_req, dec_req, exec_req})) else $error("one request"); // R10

  AST_IRQ_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CHECK && irq_pending) |-> !fetch_req) else $error("irq first"); // R2

  AST_RETIRE_NOT_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    retire_q |-> (commit_q && !trap_valid_q)) else $error("retire vs trap"); // R6

  AST_EARLY_TRAP_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_q && (kind_q == TK_IRQ || kind_q == TK_FETCH)) |-> (step_q == $past(step_q)))
    else $error("step on early trap"); // R3

  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> (done_q && !commit_q && !fetch_req)) else $error("halt sticky"); // R9

  AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (pass_q ^ fail_q)) else $error("verdict"); // R9

endmodule

// File: rtl/hss_pc.sv
module hss_pc #(
  parameter int unsigned      XLEN     = 32,
  parameter logic [XLEN-1:0]  RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            adv,
  input  logic            use_vec,
  input  logic            is_comp,
  input  logic [XLEN-1:0] trap_vec,
  output logic [XLEN-1:0] pc_o
);

  logic [XLEN-1:0] pc_q, pc_d, seq_pc;

  assign seq_pc = pc_q + (is_comp ? XLEN'(2) : XLEN'(4));

  always_comb begin
    pc_d = pc_q;
    if (adv) begin
      pc_d = use_vec ? trap_vec : seq_pc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= RESET_PC;
    end else if (adv) begin
      pc_q <= pc_d;
    end
  end

  assign pc_o = pc_q;

  AST_PC_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(pc_q)) else $error("pc moved"); // R7

endmodule

// File: rtl/hss_tick.sv
module hss_tick #(
  parameter int unsigned TICK_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic [TICK_W-1:0] limit,
  output logic              tick_o
);

  localparam int unsigned TW1 = TICK_W + 1;

  logic [TICK_W-1:0] iter_q, iter_d;
  logic              tick_d, tick_q;
  logic [TW1-1:0]    iter_inc;

  assign iter_inc = TW1'(iter_q) + TW1'(1);

  always_comb begin
    iter_d = iter_q;
    tick_d = 1'b0;
    if (adv) begin
      if (iter_inc >= TW1'(limit)) begin
        iter_d = '0;
        tick_d = 1'b1;
      end else begin
        iter_d = iter_inc[TICK_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iter_q <= '0;
      tick_q <= 1'b0;
    end else begin
      iter_q <= iter_d;
      tick_q <= tick_d;
    end
  end

  assign tick_o = tick_q;

  AST_TICK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q |-> (iter_q == '0)) else $error("tick clear"); // R8

endmodule

// File: rtl/hart_step_seq.sv
module hart_step_seq
  import hss_pkg::*;
#(
  parameter int unsigned     XLEN     = 32,
  parameter int unsigned     CAUSE_W  = 6,
  parameter int unsigned     TICK_W   = 16,
  parameter int unsigned     CNT_W    = 32,
  parameter int unsigned     EXIT_W   = 8,
  parameter logic [XLEN-1:0] RESET_PC = XLEN'(32'h0000_1000)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               irq_pending,
  input  logic [CAUSE_W-1:0] irq_cause,
  input  logic [XLEN-1:0]    trap_vec,
  output logic               fetch_req,
  input  logic               fetch_valid,
  input  logic               fetch_fault,
  input  logic [XLEN-1:0]    fetch_fault_addr,
  input  logic [31:0]        fetch_insn,
  output logic               dec_req,
  output logic [31:0]        insn_o,
  input  logic               dec_valid,
  input  logic               dec_ok,
  output logic               exec_req,
  input  logic               exec_done,
  input  logic               exec_retire,
  input  logic [TICK_W-1:0]  insns_per_tick,
  input  logic               done_in,
  input  logic [EXIT_W-1:0]  exit_code,
  output logic [XLEN-1:0]    pc_o,
  output logic               commit_o,
  output logic               retire_o,
  output logic [CNT_W-1:0]   step_count_o,
  output logic               trap_valid_o,
  output logic [1:0]         trap_kind_o,
  output logic [XLEN-1:0]    trap_val_o,
  output logic               tick_o,
  output logic               done_o,
  output logic               pass_o,
  output logic               fail_o
);

  logic [1:0] rst_sync_q;
  logic       rst_sync_n;
  logic       fin, fin_vec, is_comp;
  trap_kind_e kind;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_sync_q[1];

  hss_ctrl #(
    .XLEN(XLEN), .CAUSE_W(CAUSE_W), .CNT_W(CNT_W), .EXIT_W(EXIT_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_sync_n),
    .irq_pending(irq_pending), .irq_cause(irq_cause),
    .fetch_valid(fetch_valid), .fetch_fault(fetch_fault),
    .fetch_fault_addr(fetch_fault_addr), .fetch_insn(fetch_insn),
    .dec_valid(dec_valid), .dec_ok(dec_ok),
    .exec_done(exec_done), .exec_retire(exec_retire),
    .done_in(done_in), .exit_code(exit_code),
    .fetch_req(fetch_req), .dec_req(dec_req), .exec_req(exec_req),
    .insn_o(insn_o), .is_comp(is_comp), .fin(fin), .fin_vec(fin_vec),
    .commit_o(commit_o), .retire_o(retire_o), .trap_valid_o(trap_valid_o),
    .trap_kind_o(kind), .trap_val_o(trap_val_o), .step_count_o(step_count_o),
    .done_o(done_o), .pass_o(pass_o), .fail_o(fail_o)
  );

  assign trap_kind_o = kind;

  hss_pc #(.XLEN(XLEN), .RESET_PC(RESET_PC)) u_pc (
    .clk(clk), .rst_n(rst_sync_n), .adv(fin), .use_vec(fin_vec),
    .is_comp(is_comp), .trap_vec(trap_vec), .pc_o(pc_o)
  );

  hss_tick #(.TICK_W(TICK_W)) u_tick (
    .clk(clk), .rst_n(rst_sync_n), .adv(fin & ~done_in),
    .limit(insns_per_tick), .tick_o(tick_o)
  );

  AST_TRAP_TO_VECTOR: assert property (@(posedge clk) disable iff (!rst_sync_n)
    trap_valid_o |-> (pc_o == $past(trap_vec))) else $error("trap vector"); // R2

  AST_SEQ_PC_STEP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (commit_o && !trap_valid_o) |->
      ((pc_o == $past(pc_o) + XLEN'(2)) || (pc_o == $past(pc_o) + XLEN'(4))))
    else $error("pc step"); // R5

  AST_TICK_WITH_COMMIT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    tick_o |-> commit_o) else $error("tick commit"); // R8

  AST_NO_TICK_AT_HALT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    tick_o |-> !done_o) else $error("tick at halt"); // R9

endmodule

// File: tb/hart_step_seq_tb.sv
module hart_step_seq_tb;

  localparam int unsigned XLEN = 32;
  localparam logic [XLEN-1:0] RST_PC = 32'h0000_1000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        irq_pending = 1'b0;
  logic [5:0]  irq_cause = '0;
  logic [31:0] trap_vec = 32'h0000_0100;
  logic        fetch_req;
  logic        fetch_valid = 1'b0;
  logic        fetch_fault = 1'b0;
  logic [31:0] fetch_fault_addr = '0;
  logic [31:0] fetch_insn = '0;
  logic        dec_req;
  logic [31:0] insn_o;
  logic        dec_valid = 1'b1;
  logic        dec_ok = 1'b1;
  logic        exec_req;
  logic        exec_done = 1'b1;
  logic        exec_retire = 1'b0;
  logic [15:0] insns_per_tick = 16'd3;
  logic        done_in = 1'b0;
  logic [7:0]  exit_code = '0;
  logic [31:0] pc_o;
  logic        commit_o, retire_o, trap_valid_o, tick_o, done_o, pass_o, fail_o;
  logic [31:0] step_count_o;
  logic [1:0]  trap_kind_o;
  logic [31:0] trap_val_o;

  int unsigned checks = 0;
  int unsigned errors = 0;
  int unsigned cycles = 0;
  logic [31:0] exp_pc;
  logic [31:0] exp_step;
  int unsigned exp_iter;

  always #10 clk = ~clk;

  hart_step_seq u_dut (
    .clk(clk), .rst_n(rst_n), .irq_pending(irq_pending), .irq_cause(irq_cause),
    .trap_vec(trap_vec), .fetch_req(fetch_req), .fetch_valid(fetch_valid),
    .fetch_fault(fetch_fault), .fetch_fault_addr(fetch_fault_addr),
    .fetch_insn(fetch_insn), .dec_req(dec_req), .insn_o(insn_o),
    .dec_valid(dec_valid), .dec_ok(dec_ok), .exec_req(exec_req),
    .exec_done(exec_done), .exec_retire(exec_retire),
    .insns_per_tick(insns_per_tick), .done_in(done_in), .exit_code(exit_code),
    .pc_o(pc_o), .commit_o(commit_o), .retire_o(retire_o),
    .step_count_o(step_count_o), .trap_valid_o(trap_valid_o),
    .trap_kind_o(trap_kind_o), .trap_val_o(trap_val_o), .tick_o(tick_o),
    .done_o(done_o), .pass_o(pass_o), .fail_o(fail_o)
  );

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      checks = checks + 1;
      errors = errors + 1;
      $display("FAIL watchdog: actual=%0d expected<150000 cycles", cycles);
      summary();
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic is_c(input logic [31:0] w);
    return w[1:0] != 2'b11;
  endfunction

  function automatic logic [31:0] ill_bits(input logic [31:0] w);
    return is_c(w) ? {16'h0, w[15:0]} : w;
  endfunction

  function automatic int unsigned lat_of(input int kind);
    return kind + 1;
  endfunction

  // kind: 0 interrupt, 1 fetch fault, 2 decode failure, 3 execute
  task automatic run_iter(input int kind, input logic [31:0] w, input logic ret,
                          input logic fin_done, input logic [7:0] code,
                          input logic timing);
    int unsigned lat;
    int unsigned fetches;
    logic [31:0] vec;
    logic [31:0] pc_next;
    logic        t_exp;
    vec              = {$urandom_range(1, 255), 8'h00};
    trap_vec         = vec;
    irq_pending      = (kind == 0);
    irq_cause        = 6'($urandom);
    fetch_valid      = 1'b1;
    fetch_fault      = (kind == 1);
    fetch_fault_addr = exp_pc + ((w[1:0] == 2'b11) ? 32'd2 : 32'd0);
    fetch_insn       = w;
    dec_ok           = (kind != 2);
    exec_retire      = ret;
    done_in          = fin_done;
    exit_code        = code;
    lat = 0;
    fetches = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      lat++;
      if (commit_o) break;
      if (fetch_req) fetches++;
    end
    chk("R7", "commit pulse", 64'(commit_o), 64'd1);
    if (timing) chk("R7", "latency", 64'(lat), 64'(lat_of(kind)));
    pc_next = (kind == 3) ? exp_pc + (is_c(w) ? 32'd2 : 32'd4) : vec;
    case (kind)
      0: begin
        if (timing) chk("R2", "fetch before irq", 64'(fetches), 64'd0);
        chk("R2", "kind", 64'(trap_kind_o), 64'd1);
        chk("R2", "cause", 64'(trap_val_o), 64'(irq_cause));
        chk("R2", "pc", 64'(pc_o), 64'(pc_next));
      end
      1: begin
        chk("R3", "kind", 64'(trap_kind_o), 64'd2);
        chk("R3", "addr", 64'(trap_val_o), 64'(fetch_fault_addr));
        chk("R3", "pc", 64'(pc_o), 64'(pc_next));
      end
      2: begin
        exp_step = exp_step + 1;
        chk("R4", "kind", 64'(trap_kind_o), 64'd3);
        chk("R4", "bits", 64'(trap_val_o), 64'(ill_bits(w)));
        chk("R4", "pc", 64'(pc_o), 64'(pc_next));
      end
      default: begin
        exp_step = exp_step + 1;
        chk("R5", "pc", 64'(pc_o), 64'(pc_next));
        chk("R6", "trap flag", 64'(trap_valid_o), 64'd0);
      end
    endcase
    exp_pc = pc_next;
    chk("R6", "retire", 64'(retire_o), 64'((kind == 3) && ret));
    chk((kind < 2) ? "R3" : "R5", "steps", 64'(step_count_o), 64'(exp_step));
    t_exp = 1'b0;
    if (!fin_done) begin
      if (exp_iter + 1 >= 32'(insns_per_tick)) begin
        t_exp = 1'b1;
        exp_iter = 0;
      end else begin
        exp_iter = exp_iter + 1;
      end
    end
    chk(fin_done ? "R9" : "R8", "tick", 64'(tick_o), 64'(t_exp));
    chk("R9", "done", 64'(done_o), 64'(fin_done));
    if (fin_done) begin
      chk("R9", "pass", 64'(pass_o), 64'(code == 8'd0));
      chk("R9", "fail", 64'(fail_o), 64'(code != 8'd0));
    end
  endtask

  task automatic do_reset();
    rst_n       = 1'b0;
    irq_pending = 1'b0;
    fetch_valid = 1'b0;
    done_in     = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "pc", 64'(pc_o), 64'(RST_PC));
    chk("R1", "steps", 64'(step_count_o), 64'd0);
    chk("R1", "strobes", 64'({commit_o, retire_o, trap_valid_o, tick_o}), 64'd0);
    chk("R1", "verdict", 64'({done_o, pass_o, fail_o}), 64'd0);
    exp_pc   = RST_PC;
    exp_step = '0;
    exp_iter = 0;
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [31:0] rnd_insn();
    return $urandom;
  endfunction

  task automatic check_halted();
    logic [31:0] pc_hold;
    pc_hold     = pc_o;
    irq_pending = 1'b0;
    fetch_valid = 1'b1;
    done_in     = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (commit_o || fetch_req || dec_req || exec_req || (pc_o != pc_hold)) begin
        chk("R9", "activity after halt", 64'({commit_o, fetch_req, pc_o}), 64'({1'b0, 1'b0, pc_hold}));
        break;
      end
    end
    chk("R9", "pc held", 64'(pc_o), 64'(pc_hold));
    chk("R9", "done sticky", 64'(done_o), 64'd1);
  endtask

  initial begin
    void'($urandom(32'd20240517));
    do_reset();
    // first iteration starts from a waiting fetch, so latency is not checked
    run_iter(3, 32'h0000_4501, 1'b1, 1'b0, 8'd0, 1'b0);
    run_iter(0, '0, 1'b0, 1'b0, 8'd0, 1'b1);
    run_iter(1, 32'h0000_0013, 1'b0, 1'b0, 8'd0, 1'b1);
    run_iter(2, 32'hABCD_0001, 1'b0, 1'b0, 8'd0, 1'b1);
    run_iter(2, 32'hABCD_00B3, 1'b0, 1'b0, 8'd0, 1'b1);
    run_iter(3, 32'h1234_5003, 1'b0, 1'b0, 8'd0, 1'b1);
    run_iter(3, 32'hFFFF_FFFE, 1'b1, 1'b0, 8'd0, 1'b1);
    for (int n = 0; n < 300; n++) begin
      int r;
      int k;
      r = int'($urandom_range(0, 99));
      k = (r < 15) ? 0 : (r < 30) ? 1 : (r < 45) ? 2 : 3;
      if ($urandom_range(0, 19) == 0) insns_per_tick = 16'($urandom_range(1, 7));
      run_iter(k, rnd_insn(), 1'($urandom), 1'b0, 8'd0, 1'b1);
    end
    run_iter(3, 32'h0000_0033, 1'b1, 1'b1, 8'd0, 1'b1);
    check_halted();

    do_reset();
    insns_per_tick = 16'd1;
    run_iter(1, 32'h0000_0003, 1'b0, 1'b0, 8'd0, 1'b0);
    for (int n = 0; n < 6; n++) begin
      run_iter(int'($urandom_range(0, 3)), rnd_insn(), 1'b1, 1'b0, 8'd0, 1'b1);
    end
    run_iter(0, '0, 1'b0, 1'b1, 8'd5, 1'b1);
    check_halted();
    summary();
  end

endmodule